// File: doc/BRIEF.md
# USART host register interface

This block is the processor-facing front end of a USART. A host reaches it through an 8-bit data bus, an active-low chip select, active-low read and write strobes, and a control/data select line. A data write fills the transmit holding register and tells the transmitter that a byte is waiting. A control write loads either the mode register or the command register. A data read returns the receiver's byte and tells the receiver that it has been taken. A control read returns a status byte assembled from the transmitter and receiver flags and the modem DSR pin.

Control writes follow a fixed order. The first control write after reset is taken as the mode byte. Every later control write is taken as a command byte. A command that carries the internal-reset bit clears the command and mode registers and restarts this order. The command register drives the active-low DTR and RTS pins. The error-clear and internal-reset bits are delivered as one-cycle pulses and are not stored. All strobes are sampled on the block clock. Each access acts once, in its first sampled cycle, however long the strobe is held.

Top module: `usart_host_regs`

## Requirements
- R1: After reset `mode_byte` and `cmd_byte` are 0x00, `dtr_n` and `rts_n` are 1, no pulse output is high, and the next control write is taken as the mode byte.
- R2: A write access is `cs_n`=0, `wr_n`=0 and `rd_n`=1. It acts only in its first sampled cycle, so a strobe held low for several cycles gives exactly one single-cycle pulse.
- R3: A data write (`cd`=0) places `din` on `tx_data`. `tx_load` is high for the one cycle that follows the clock edge at which the write was first sampled.
- R4: The first control write (`cd`=1) after reset or internal reset loads `mode_byte` and leaves `cmd_byte` unchanged. The mode fields are: stop bits [7:6], parity type [5], parity enable [4], character length [3:2] and baud factor [1:0].
- R5: Each later control write loads `cmd_byte`. The command bits are: hunt [7], internal reset [6], RTS [5], error clear [4], break [3], receive enable [2], DTR [1] and transmit enable [0]. Bits 6 and 4 always read 0 in `cmd_byte`. `dtr_n` is the inverse of bit 1 and `rts_n` is the inverse of bit 5.
- R6: A command write with bit 4 set, and bit 6 clear, raises `err_clr` for exactly one cycle.
- R7: A command write with bit 6 set raises `int_rst` for one cycle. It clears `cmd_byte` and `mode_byte`, which drives `dtr_n` and `rts_n` high, and the next control write is again taken as the mode byte. The other bits of that byte are ignored.
- R8: A data read (`cs_n`=0, `rd_n`=0, `wr_n`=1, `cd`=0) drives `rx_data` onto `dout` while the strobe is low. `rx_taken` is high for exactly one cycle per access.
- R9: A control read drives the status byte onto `dout`: [7] is the inverse of `dsr_n`, [6] is 0, [5] is `fe`, [4] is `oe`, [3] is `pe`, [2] is `tx_empty`, [1] is `rx_ready` and [0] is `tx_ready`. A control read does not raise `rx_taken`.
- R10: When no read access is active, `dout` is 0x00. An access with `cs_n` high, or with both strobes low, changes no register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 0 selects data, 1 selects control/status |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host |
| dsr_n | input | 1 | Modem data-set-ready pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_ready | input | 1 | Transmitter can accept a byte |
| tx_empty | input | 1 | Transmitter fully idle |
| rx_ready | input | 1 | Receiver holds a byte |
| fe | input | 1 | Receiver framing error |
| oe | input | 1 | Receiver overrun error |
| pe | input | 1 | Receiver parity error |
| rx_data | input | 8 | Byte from the receiver |
| tx_data | output | 8 | Transmit holding register |
| tx_load | output | 1 | One-cycle pulse: a new byte is in `tx_data` |
| rx_taken | output | 1 | One-cycle pulse: the host read the received byte |
| mode_byte | output | 8 | Mode register, to transmitter and receiver |
| cmd_byte | output | 8 | Command register, with bits 6 and 4 reading 0 |
| err_clr | output | 1 | One-cycle error-clear pulse |
| int_rst | output | 1 | One-cycle internal-reset pulse |

## Verification
The hardest condition to reach is the return to mode-byte expectation after an internal reset. It depends on history: a mode byte must already have been accepted, then a command carrying the internal-reset bit must arrive, possibly together with other set bits. The stimulus table walks the full sequence twice. It goes mode, commands, an internal-reset command, then a fresh mode byte. The second pass uses an internal-reset byte that also has DTR and RTS set, to show those bits are dropped. Directed tests then hold a strobe for several cycles and drive both strobes low at once, confirming that only one pulse, or none, results.

// File: rtl/usart_host_pkg.sv
// Shared constants for the USART host register interface.
// Assumes an 8-bit host bus. The bit positions below are decoded by the
// transmitter and receiver, so they must not move.
package usart_host_pkg;
    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] hbyte_t;

    // Command register bit positions
    localparam int CMD_TXEN = 0;
    localparam int CMD_DTR  = 1;
    localparam int CMD_RXEN = 2;
    localparam int CMD_BRK  = 3;
    localparam int CMD_ERR  = 4;
    localparam int CMD_RTS  = 5;
    localparam int CMD_IRST = 6;
    localparam int CMD_HUNT = 7;

    // Bits that act as pulses and are never stored
    localparam hbyte_t CMD_PULSE_MASK = hbyte_t'((1 << CMD_ERR) | (1 << CMD_IRST));

    // Index of each access type in the decoder vectors
    localparam int ACC_WR = 0;
    localparam int ACC_RD = 1;
    localparam int ACC_N  = 2;
endpackage

// File: rtl/usart_bus_decode.sv
// Host strobe decoder.
// It qualifies the read and write accesses and finds the first sampled cycle
// of each. An access with both strobes low is treated as no access.
// Assumes the strobes are synchronous to clk.
module usart_bus_decode
    import usart_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic cd,
    output logic wr_data_stb,
    output logic wr_ctl_stb,
    output logic rd_data_stb,
    output logic rd_active
);
    logic [ACC_N-1:0] acc;
    logic [ACC_N-1:0] acc_q;
    logic [ACC_N-1:0] first;

    // Qualify each access type
    always_comb begin
        acc[ACC_WR] = !cs_n && !wr_n && rd_n;
        acc[ACC_RD] = !cs_n && !rd_n && wr_n;
    end

    // One edge detector per access type
    for (genvar i = 0; i < ACC_N; i++) begin : g_edge
        // Remember whether the access was active in the previous cycle
        always_ff @(posedge clk) begin
            if (!rst_n) acc_q[i] <= 1'b0;
            else        acc_q[i] <= acc[i];
        end
        assign first[i] = acc[i] && !acc_q[i];
    end

    // Split the first cycle by the control/data select
    always_comb begin
        wr_data_stb = first[ACC_WR] && !cd;
        wr_ctl_stb  = first[ACC_WR] && cd;
        rd_data_stb = first[ACC_RD] && !cd;
        rd_active   = acc[ACC_RD];
    end
endmodule

// File: rtl/usart_ctl_seq.sv
// Control write sequencer.
// It holds the mode and command registers and steers each control write to
// one of them. The first control write after reset or internal reset goes
// to mode, and later writes go to command. The error-clear and internal-reset
// bits become one-cycle pulses.
module usart_ctl_seq
    import usart_host_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_ctl_stb,
    input  hbyte_t din,
    output hbyte_t mode_byte,
    output hbyte_t cmd_byte,
    output logic   err_clr,
    output logic   int_rst,
    output logic   expect_mode
);
    // Register update for the mode/command sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_byte   <= '0;
            cmd_byte    <= '0;
            expect_mode <= 1'b1;
            err_clr     <= 1'b0;
            int_rst     <= 1'b0;
        end else begin
            err_clr <= 1'b0;
            int_rst <= 1'b0;
            if (wr_ctl_stb) begin
                if (expect_mode) begin
                    mode_byte   <= din;
                    expect_mode <= 1'b0;
                end else if (din[CMD_IRST]) begin
                    mode_byte   <= '0;
                    cmd_byte    <= '0;
                    expect_mode <= 1'b1;
                    int_rst     <= 1'b1;
                end else begin
                    cmd_byte <= din & ~CMD_PULSE_MASK;
                    err_clr  <= din[CMD_ERR];
                end
            end
        end
    end
endmodule

// File: rtl/usart_read_mux.sv
// Read data selector.
// It returns received data or the assembled status byte while a read
// is active, and 0x00 otherwise. The synchronous-detect flag is fixed at 0.
module usart_read_mux
    import usart_host_pkg::*;
(
    input  logic   rd_active,
    input  logic   cd,
    input  hbyte_t rx_data,
    input  logic   dsr_n,
    input  logic   fe,
    input  logic   oe,
    input  logic   pe,
    input  logic   tx_empty,
    input  logic   rx_ready,
    input  logic   tx_ready,
    output hbyte_t dout
);
    hbyte_t status;

    // Assemble the status byte in its fixed layout
    always_comb begin
        status = {!dsr_n, 1'b0, fe, oe, pe, tx_empty, rx_ready, tx_ready};
    end

    // Drive the bus only during a read
    always_comb begin
        if (!rd_active) dout = '0;
        else if (cd)    dout = status;
        else            dout = rx_data;
    end
endmodule

// File: rtl/usart_host_regs.sv
// USART host register interface (top).
// It decodes host accesses, holds the transmit byte and the mode and command
// registers, drives DTR/RTS, and returns data or status on reads.
// Assumes synchronous host strobes and a synchronous active-low reset.
module usart_host_regs
    import usart_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       cd,
    input  logic [7:0] din,
    output logic [7:0] dout,
    input  logic       dsr_n,
    output logic       dtr_n,
    output logic       rts_n,
    input  logic       tx_ready,
    input  logic       tx_empty,
    input  logic       rx_ready,
    input  logic       fe,
    input  logic       oe,
    input  logic       pe,
    input  logic [7:0] rx_data,
    output logic [7:0] tx_data,
    output logic       tx_load,
    output logic       rx_taken,
    output logic [7:0] mode_byte,
    output logic [7:0] cmd_byte,
    output logic       err_clr,
    output logic       int_rst
);
    logic wr_data_stb;
    logic wr_ctl_stb;
    logic rd_data_stb;
    logic rd_active;
    logic expect_mode;

    usart_bus_decode dec_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .cd          (cd),
        .wr_data_stb (wr_data_stb),
        .wr_ctl_stb  (wr_ctl_stb),
        .rd_data_stb (rd_data_stb),
        .rd_active   (rd_active)
    );

    usart_ctl_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctl_stb  (wr_ctl_stb),
        .din         (din),
        .mode_byte   (mode_byte),
        .cmd_byte    (cmd_byte),
        .err_clr     (err_clr),
        .int_rst     (int_rst),
        .expect_mode (expect_mode)
    );

    usart_read_mux mux_i (
        .rd_active (rd_active),
        .cd        (cd),
        .rx_data   (rx_data),
        .dsr_n     (dsr_n),
        .fe        (fe),
        .oe        (oe),
        .pe        (pe),
        .tx_empty  (tx_empty),
        .rx_ready  (rx_ready),
        .tx_ready  (tx_ready),
        .dout      (dout)
    );

    // Transmit holding register and the pulses to the transmitter and receiver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_load  <= 1'b0;
            rx_taken <= 1'b0;
        end else begin
            tx_load  <= wr_data_stb;
            rx_taken <= rd_data_stb;
            if (wr_data_stb) tx_data <= din;
        end
    end

    // Modem control pins, active low
    assign dtr_n = !cmd_byte[CMD_DTR];
    assign rts_n = !cmd_byte[CMD_RTS];
endmodule

// File: rtl/usart_host_regs_chk.sv
// Assertion checker for usart_host_regs, attached by bind.
// Assumes the internal nets wr_ctl_stb and expect_mode exist in the top.
module usart_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       cd,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       tx_load,
    input logic       rx_taken,
    input logic [7:0] mode_byte,
    input logic [7:0] cmd_byte,
    input logic       err_clr,
    input logic       int_rst,
    input logic       wr_ctl_stb,
    input logic       expect_mode
);
    // R4: a write in the mode phase loads mode and ends the mode phase
    a_r4_mode_first: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl_stb && expect_mode |=> !expect_mode && (mode_byte == $past(din)));

    // R5: a plain command write sets the modem pins from its bits
    a_r5_pins_follow_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl_stb && !expect_mode && !din[6]
        |=> (dtr_n == !$past(din[1])) && (rts_n == !$past(din[5])));

    // R6: the error-clear pulse lasts one cycle
    a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !err_clr);

    // R7: internal reset restarts the sequence
    a_r7_irst_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl_stb && !expect_mode && din[6]
        |=> int_rst && expect_mode && (cmd_byte == 8'h00) && dtr_n && rts_n);

    // R2: a transmit load never lasts two cycles
    a_r2_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);

    // R8: the received-byte pulse lasts one cycle
    a_r8_taken_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_taken |=> !rx_taken);

    // R9: the synchronous-detect status bit reads 0
    a_r9_syndet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n && !rd_n && wr_n && cd |-> !dout[6]);

    // R10: the bus is 0x00 when no read is active
    a_r10_dout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n || rd_n || !wr_n |-> dout == 8'h00);
endmodule

bind usart_host_regs usart_host_regs_chk chk_i (.*);

// File: tb/usart_host_regs_tb_top.sv
// Self-checking bench for usart_host_regs: a vector table walk, then directed tests.
module usart_host_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dsr_n = 1'b1;
    logic       dtr_n, rts_n;
    logic       tx_ready = 1'b0, tx_empty = 1'b0, rx_ready = 1'b0;
    logic       fe = 1'b0, oe = 1'b0, pe = 1'b0;
    logic [7:0] rx_data = '0;
    logic [7:0] tx_data;
    logic       tx_load, rx_taken, err_clr, int_rst;
    logic [7:0] mode_byte, cmd_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usart_host_regs dut_i (.*);

    // Row fields: cd, din, mode, cmd, dtr_n, rts_n, tx_load, err_clr, int_rst
    localparam int NV = 10;
    localparam logic [29:0] VEC [0:NV-1] = '{
        {1'b1, 8'h4E, 8'h4E, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h23, 8'h4E, 8'h23, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 8'h5A, 8'h4E, 8'h23, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h16, 8'h4E, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'h40, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {1'b1, 8'hFB, 8'hFB, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h88, 8'hFB, 8'h88, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h62, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {1'b1, 8'h01, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b0, 8'h00, 8'h01, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic p_load, p_err, p_irst;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write access, held for hold cycles; the pulses are captured after the first edge
    task automatic do_write(input logic c, input logic [7:0] d, input int hold);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; cd = c; din = d;
        @(negedge clk);
        p_load = tx_load; p_err = err_clr; p_irst = int_rst;
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            chk("R2 held write repeat pulse", {5'b0, tx_load, err_clr, int_rst}, 8'h00);
        end
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode reset", mode_byte, 8'h00);
        chk("R1 cmd reset", cmd_byte, 8'h00);
        chk("R1 pins/pulses reset", {2'b0, dtr_n, rts_n, tx_load, rx_taken, err_clr, int_rst}, 8'h30);
        chk("R10 dout idle", dout, 8'h00);

        // Table walk (R4, R5, R6, R7, R3)
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][29], VEC[i][28:21], 1);
            @(negedge clk);
            chk($sformatf("R4 mode row %0d", i), mode_byte, VEC[i][20:13]);
            chk($sformatf("R5 cmd row %0d", i), cmd_byte, VEC[i][12:5]);
            chk($sformatf("R5 pins row %0d", i), {6'b0, dtr_n, rts_n}, {6'b0, VEC[i][4:3]});
            chk($sformatf("R3 load row %0d", i), {7'b0, p_load}, {7'b0, VEC[i][2]});
            chk($sformatf("R6 err row %0d", i), {7'b0, p_err}, {7'b0, VEC[i][1]});
            chk($sformatf("R7 irst row %0d", i), {7'b0, p_irst}, {7'b0, VEC[i][0]});
            chk($sformatf("R2 pulses gone row %0d", i), {5'b0, tx_load, err_clr, int_rst}, 8'h00);
        end

        // R3: transmit byte value
        do_write(1'b0, 8'hA7, 1);
        chk("R3 tx_data", tx_data, 8'hA7);
        // R2: a data write held four cycles gives one pulse
        do_write(1'b0, 8'h3C, 4);
        chk("R2 held write first pulse", {7'b0, p_load}, 8'h01);
        // R2: a command write held three cycles
        do_write(1'b1, 8'h02, 3);
        @(negedge clk);
        chk("R2 held cmd value", cmd_byte, 8'h02);

        // R10: both strobes low is ignored
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; cd = 1'b1; din = 8'hFF;
        repeat (2) @(negedge clk);
        chk("R10 both strobes cmd", cmd_byte, 8'h02);
        chk("R10 both strobes dout", dout, 8'h00);
        chk("R10 both strobes pulses", {5'b0, tx_load, err_clr, int_rst}, 8'h00);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        // R10: cs_n high is ignored
        @(negedge clk);
        wr_n = 1'b0; cd = 1'b0; din = 8'h99;
        repeat (2) @(negedge clk);
        chk("R10 deselected tx_data", tx_data, 8'h3C);
        chk("R10 deselected load", {7'b0, tx_load}, 8'h00);
        wr_n = 1'b1;

        // R8: data read
        rx_data = 8'hC3;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; cd = 1'b0;
        #1 chk("R8 dout data", dout, 8'hC3);
        @(negedge clk);
        chk("R8 taken pulse", {7'b0, rx_taken}, 8'h01);
        @(negedge clk);
        chk("R8 taken single", {7'b0, rx_taken}, 8'h00);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        chk("R10 dout after read", dout, 8'h00);

        // R9: status reads
        dsr_n = 1'b0; fe = 1'b1; oe = 1'b0; pe = 1'b1;
        tx_empty = 1'b0; rx_ready = 1'b1; tx_ready = 1'b1;
        cs_n = 1'b0; rd_n = 1'b0; cd = 1'b1;
        #1 chk("R9 status A", dout, 8'hAB);
        @(negedge clk);
        chk("R9 no taken on status", {7'b0, rx_taken}, 8'h00);
        dsr_n = 1'b1; fe = 1'b0; pe = 1'b0; rx_ready = 1'b0; tx_ready = 1'b0; tx_empty = 1'b1;
        #1 chk("R9 status B", dout, 8'h04);
        dsr_n = 1'b1; oe = 1'b1; tx_empty = 1'b0;
        #1 chk("R9 status C", dout, 8'h10);
        cs_n = 1'b1; rd_n = 1'b1;

        // R1: reset restores the mode phase
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 cmd after reset", cmd_byte, 8'h00);
        do_write(1'b1, 8'h77, 1);
        @(negedge clk);
        chk("R1 first write is mode", mode_byte, 8'h77);
        chk("R1 cmd untouched", cmd_byte, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule